// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit sits beside a single processor core and supplies its two core-local interrupt sources. A 64-bit time counter advances by one on every clock, and a 64-bit compare register holds the next deadline. While the time value is at or past the deadline, a level-sensitive timer-pending line to the core stays high. A separate one-bit software-interrupt register drives a software-pending line. The core can use it to signal itself, or it can be set from another context.

Software reaches all registers through a 32-bit memory-mapped port with a valid/ready handshake. The unit claims a fixed 48 KiB window of the physical address space. Each 64-bit register is accessed as a low word and a high word. A kernel reprograms the deadline with three stores: low half to all-ones, then high half to zero, then low half to the real deadline. Written in that order, the compare never falls below the running time in between. For example, with a 50 MHz clock, a deadline 500000 counts ahead fires after 10 ms, so re-arming it each time gives a 100 Hz tick.

The port is managed by a two-state machine. State BUS_IDLE waits for a request. The transition BUS_IDLE to BUS_ACK is taken when valid is high and the address is claimed, and the request is latched on that transition. In state BUS_ACK, ready is high for one cycle, read data is driven, and a write takes effect. The transition BUS_ACK to BUS_IDLE is then taken unconditionally.

Top module: `core_tick_irq`

## Requirements
- R1: `bus_claim` is high exactly when `bus_addr` lies in 0x02000000..0x0200BFFF. A request to an unclaimed address never gets `bus_ready` and changes no register.
- R2: A claimed request presented in BUS_IDLE gets `bus_ready` high on the next cycle, for exactly one cycle. A write commits at the edge that ends that cycle. `bus_rdata` is valid while `bus_ready` is high and is zero otherwise.
- R3: Word offsets in the window select the registers: 0x4000 is compare low, 0x4004 is compare high, 0xBFF8 is time low, 0xBFFC is time high, and 0x0000 is the software word.
- R4: The time counter resets to zero and increments by one on every clock. A carry passes from the low half into the high half.
- R5: A write to time low replaces the low half and leaves the high half unchanged. A write to time high replaces the high half while the low half keeps counting, and any carry from the low half in that cycle is dropped. Counting resumes from the written value on the following clock.
- R6: The compare register resets to all-ones, so `irq_timer` is low out of reset. Each compare half is written independently.
- R7: `irq_timer` is high exactly when the unsigned 64-bit time is greater than or equal to the 64-bit compare value. It stays high until the compare or the time is rewritten.
- R8: After a deadline has passed, the store sequence compare-low = 0xFFFFFFFF, compare-high = 0, compare-low = deadline holds `irq_timer` low from the first store until time reaches the new deadline. This applies while the time high half is zero.
- R9: With time = 0 and compare = D, `irq_timer` rises on the clock at which time becomes D.
- R10: `irq_soft` equals bit 0 of the software word and resets to 0. Bits 31..1 of that word ignore writes and read as zero.
- R11: Other offsets inside the window read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request valid, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_claim | output | 1 | Address falls in this unit's window |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with ready |
| irq_timer | output | 1 | Timer interrupt pending (level) |
| irq_soft | output | 1 | Software interrupt pending (level) |

## Verification
A software write to a time half can land in the same cycle as the counter's own increment. The hardest such case is a write to the high half at the moment the low half wraps from all-ones to zero. The bench provokes this case by loading the low half with 0xFFFFFFFE and then writing the high half two edges later. It checks that the low half reads as the wrapped value and that the high half reads exactly the written value, with no carry added. A second coincidence is a compare store landing while time is near the old deadline. This is judged by watching `irq_timer` on every cycle of the three-store sequence.

// File: rtl/ciu_pkg.sv
package ciu_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SOFT,
        RG_CMP_LO,
        RG_CMP_HI,
        RG_TIME_LO,
        RG_TIME_HI
    } reg_sel_e;

    localparam logic [15:0] OFS_SOFT    = 16'h0000;
    localparam logic [15:0] OFS_CMP_LO  = 16'h4000;
    localparam logic [15:0] OFS_CMP_HI  = 16'h4004;
    localparam logic [15:0] OFS_TIME_LO = 16'hBFF8;
    localparam logic [15:0] OFS_TIME_HI = 16'hBFFC;

    function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
        reg_sel_e r;
        case (ofs)
            OFS_SOFT:    r = RG_SOFT;
            OFS_CMP_LO:  r = RG_CMP_LO;
            OFS_CMP_HI:  r = RG_CMP_HI;
            OFS_TIME_LO: r = RG_TIME_LO;
            OFS_TIME_HI: r = RG_TIME_HI;
            default:     r = RG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ciu_bus_fsm.sv
module ciu_bus_fsm
    import ciu_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
    parameter int unsigned WIN_BYTES = 32'h0000_C000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          claim,
    output logic          ready,
    output logic          wr_strobe,
    output reg_sel_e      req_sel,
    output logic [DW-1:0] req_wdata
);
    localparam logic [AW-1:0] WIN_FIRST = AW'(BASE_ADDR);
    localparam logic [AW-1:0] WIN_LAST  = AW'(BASE_ADDR) + AW'(WIN_BYTES) - AW'(1);

    bus_state_e state_q, state_nx;
    logic       req_we;
    logic [15:0] ofs;

    assign claim = (addr >= WIN_FIRST) && (addr <= WIN_LAST);
    assign ofs   = addr[15:0] - BASE_ADDR[15:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            BUS_IDLE: if (valid && claim) state_nx = BUS_ACK;
            BUS_ACK:  state_nx = BUS_IDLE;
        endcase
    end

    // request latch, taken on the BUS_IDLE -> BUS_ACK transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_sel   <= RG_NONE;
            req_wdata <= '0;
        end else if (state_q == BUS_IDLE && valid && claim) begin
            req_we    <= write;
            req_sel   <= decode_offset(ofs);
            req_wdata <= wdata;
        end
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        wr_strobe = 1'b0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_ACK: begin
                ready     = 1'b1;
                wr_strobe = req_we;
            end
        endcase
    end

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R1
    unclaimed_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && !(valid && claim)) |=> !ready);

endmodule

// File: rtl/ciu_timebase.sv
module ciu_timebase #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] time_q
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] inc, time_nx;

    assign inc = time_q + FULL_W'(1);

    always_comb begin
        time_nx = inc;
        if (wr_lo) time_nx = {time_q[FULL_W-1:HALF_W], wdata};
        if (wr_hi) time_nx = {wdata, inc[HALF_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_nx;
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> time_q == $past(time_q) + FULL_W'(1));
    // R5
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> time_q[FULL_W-1:HALF_W] == $past(time_q[FULL_W-1:HALF_W]));
    // R5
    hi_write_lo_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> time_q[HALF_W-1:0] == $past(time_q[HALF_W-1:0]) + HALF_W'(1));

endmodule

// File: rtl/ciu_compare.sv
module ciu_compare #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [2*HALF_W-1:0] time_q,
    output logic [2*HALF_W-1:0] cmp_q,
    output logic                pend
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else begin
            if (wr_lo) cmp_q[HALF_W-1:0]      <= wdata;
            if (wr_hi) cmp_q[FULL_W-1:HALF_W] <= wdata;
        end
    end

    assign pend = (time_q >= cmp_q);

    // R6
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> $stable(cmp_q));

endmodule

// File: rtl/core_tick_irq.sv
module core_tick_irq
    import ciu_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
    parameter int unsigned WIN_BYTES = 32'h0000_C000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [31:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_claim,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_timer,
    output logic              irq_soft
);
    localparam int unsigned TIME_W = 2 * DATA_W;

    logic              wr_strobe;
    reg_sel_e          req_sel;
    logic [DATA_W-1:0] req_wdata;
    logic [TIME_W-1:0] time_q, cmp_q;
    logic              soft_q;
    logic              wr_soft, wr_cmp_lo, wr_cmp_hi, wr_time_lo, wr_time_hi;
    logic [DATA_W-1:0] rd_mux;

    ciu_bus_fsm #(
        .AW(32), .DW(DATA_W), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)
    ) u_port (
        .clk(clk), .rst_n(rst_n),
        .valid(bus_valid), .write(bus_write), .addr(bus_addr), .wdata(bus_wdata),
        .claim(bus_claim), .ready(bus_ready), .wr_strobe(wr_strobe),
        .req_sel(req_sel), .req_wdata(req_wdata)
    );

    assign wr_soft    = wr_strobe && (req_sel == RG_SOFT);
    assign wr_cmp_lo  = wr_strobe && (req_sel == RG_CMP_LO);
    assign wr_cmp_hi  = wr_strobe && (req_sel == RG_CMP_HI);
    assign wr_time_lo = wr_strobe && (req_sel == RG_TIME_LO);
    assign wr_time_hi = wr_strobe && (req_sel == RG_TIME_HI);

    ciu_timebase #(.HALF_W(DATA_W)) u_time (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_time_lo), .wr_hi(wr_time_hi), .wdata(req_wdata),
        .time_q(time_q)
    );

    ciu_compare #(.HALF_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wdata(req_wdata),
        .time_q(time_q), .cmp_q(cmp_q), .pend(irq_timer)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       soft_q <= 1'b0;
        else if (wr_soft) soft_q <= req_wdata[0];
    end
    assign irq_soft = soft_q;

    always_comb begin
        case (req_sel)
            RG_SOFT:    rd_mux = DATA_W'(soft_q);
            RG_CMP_LO:  rd_mux = cmp_q[DATA_W-1:0];
            RG_CMP_HI:  rd_mux = cmp_q[TIME_W-1:DATA_W];
            RG_TIME_LO: rd_mux = time_q[DATA_W-1:0];
            RG_TIME_HI: rd_mux = time_q[TIME_W-1:DATA_W];
            default:    rd_mux = '0;
        endcase
    end
    assign bus_rdata = bus_ready ? rd_mux : '0;

    // R7
    timer_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_timer && !wr_cmp_lo && !wr_cmp_hi && !wr_time_lo && !wr_time_hi) |=> irq_timer);
    // R10
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_soft |=> $stable(irq_soft));
    // R2
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> bus_rdata == '0);

endmodule

// File: tb/test_core_tick_irq.sv
`timescale 1ns/1ps
module test_core_tick_irq;

    localparam logic [31:0] BASE = 32'h0200_0000;
    localparam logic [31:0] A_SOFT = BASE + 32'h0000;
    localparam logic [31:0] A_CLO  = BASE + 32'h4000;
    localparam logic [31:0] A_CHI  = BASE + 32'h4004;
    localparam logic [31:0] A_TLO  = BASE + 32'hBFF8;
    localparam logic [31:0] A_THI  = BASE + 32'hBFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_claim, bus_ready, irq_timer, irq_soft;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    int spurious = 0;
    logic mon_en = 1'b0;

    always #2 clk = ~clk;

    core_tick_irq i_core_tick_irq (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_claim(bus_claim), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .irq_timer(irq_timer), .irq_soft(irq_soft)
    );

    always @(negedge clk) if (mon_en && irq_timer) spurious++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic bus_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q);
        bus_valid = 1'b1; bus_write = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        q = bus_rdata;
        if (bus_ready !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R2: ready actual=%0b expected=1", bus_ready);
        end
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus_op(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] q);
        bus_op(1'b0, a, 32'h0, q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R2: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] q, q2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R6 reset irq_timer", irq_timer, 0);
        chk("R10 reset irq_soft", irq_soft, 0);
        chk("R2 ready idle", bus_ready, 0);
        rd(A_THI, q); chk("R4 reset time hi", q, 0);
        rd(A_CLO, q); chk("R6 reset cmp lo", q, 32'hFFFF_FFFF);
        rd(A_CHI, q); chk("R6 reset cmp hi", q, 32'hFFFF_FFFF);
        rd(A_SOFT, q); chk("R10 reset soft word", q, 0);

        // R1 window sweep
        begin
            logic [31:0] addrs [7] = '{32'h0000_0000, 32'h01FF_FFFC, 32'h0200_0000,
                32'h0200_BFFC, 32'h0200_BFFF, 32'h0200_C000, 32'h0300_0000};
            foreach (addrs[i]) begin
                bus_addr = addrs[i]; #1;
                chk("R1 claim", bus_claim,
                    (addrs[i] >= 32'h0200_0000 && addrs[i] <= 32'h0200_BFFF));
            end
        end
        // unclaimed write attempt: never acknowledged, no effect
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h0200_C000; bus_wdata = 32'h0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R1 unclaimed no ready", bus_ready, 0);
        end
        bus_valid = 1'b0;
        rd(A_CLO, q); chk("R1 unclaimed no effect", q, 32'hFFFF_FFFF);

        // R11 holes
        rd(BASE + 32'h8, q); chk("R11 hole reads zero", q, 0);
        wr(BASE + 32'h4008, 32'h0000_ABCD);
        rd(A_CLO, q); chk("R11 hole write ignored", q, 32'hFFFF_FFFF);

        // R3 compare halves readable/writable
        wr(A_CHI, 32'h0000_1357);
        rd(A_CHI, q); chk("R3 cmp hi", q, 32'h0000_1357);
        rd(A_CLO, q); chk("R6 cmp lo independent", q, 32'hFFFF_FFFF);

        // R4 step between consecutive reads (two clocks apart)
        rd(A_TLO, q); rd(A_TLO, q2); chk("R4 increments", q2 - q, 2);

        // R10 software word
        wr(A_SOFT, 32'hFFFF_FFFF);
        chk("R10 soft set", irq_soft, 1);
        rd(A_SOFT, q); chk("R10 upper bits read zero", q, 1);
        wr(A_SOFT, 32'hFFFF_FFFE);
        chk("R10 soft clear", irq_soft, 0);
        rd(A_SOFT, q); chk("R10 soft word", q, 0);

        // R5 low write keeps high
        wr(A_THI, 32'h9);
        wr(A_TLO, 32'h1234);
        rd(A_TLO, q); chk("R5 lo resumes", q, 32'h1235);
        rd(A_THI, q); chk("R5 hi kept", q, 32'h9);

        // R5 collision: high write when low wraps in the same cycle
        wr(A_THI, 32'h5);
        wr(A_TLO, 32'hFFFF_FFFE);
        wr(A_THI, 32'h7);
        rd(A_TLO, q); chk("R5 collision lo", q, 32'h1);
        rd(A_THI, q); chk("R5 collision hi no carry", q, 32'h7);

        // R4 carry
        wr(A_THI, 32'h0);
        wr(A_TLO, 32'hFFFF_FFFF);
        rd(A_THI, q); chk("R4 carry into hi", q, 32'h1);

        // R7 comparator sweep, compare = {1, 0x100}
        wr(A_CLO, 32'hFFFF_FFFF);
        wr(A_CHI, 32'h1);
        wr(A_CLO, 32'h100);
        for (int th = 0; th < 3; th++) begin
            for (int d = -2; d <= 2; d++) begin
                wr(A_THI, 32'(th));
                wr(A_TLO, 32'(32'h100 + d));
                chk($sformatf("R7 th=%0d d=%0d", th, d), irq_timer,
                    (th > 1) || (th == 1 && d >= 0));
            end
        end

        // R9 deadline
        wr(A_CLO, 32'hFFFF_FFFF);
        wr(A_CHI, 32'h0);
        wr(A_THI, 32'h0);
        wr(A_TLO, 32'h0);
        wr(A_CLO, 32'd5000);
        chk("R9 armed low", irq_timer, 0);
        repeat (5000 - 3) @(negedge clk);
        chk("R9 one before deadline", irq_timer, 0);
        @(negedge clk);
        chk("R9 at deadline", irq_timer, 1);
        repeat (10) @(negedge clk);
        chk("R7 level held", irq_timer, 1);

        // R8 three-store reprogram after a passed deadline
        wr(A_THI, 32'h0);
        wr(A_TLO, 32'd100);
        wr(A_CLO, 32'h0);
        chk("R8 passed deadline pending", irq_timer, 1);
        wr(A_CLO, 32'hFFFF_FFFF);
        chk("R8 first store clears", irq_timer, 0);
        mon_en = 1'b1;
        wr(A_CHI, 32'h0);
        wr(A_CLO, 32'd400);
        repeat (291) @(negedge clk);
        mon_en = 1'b0;
        chk("R8 no spurious pending", spurious, 0);
        @(negedge clk);
        chk("R8 fires at new deadline", irq_timer, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule